// File: doc/BRIEF.md
# Host Command Sequencer with Table Loader

This block sits on a simple host register bus and runs short multi-cycle commands for the host. The host first places up to two 16-bit operands in two write-only data registers. It then writes an 8-bit command code. That write starts execution. While the command runs, the block reports busy and ignores further writes to the operand and command registers.

When the command finishes, the command register returns to zero, a done flag in the status register rises, and any result is placed in the 16-bit output register. Reading the status register clears the done flag.

The commands cover three areas:
- Loading an internal transmit event table through a hidden auto-incrementing pointer. There are one-word and two-word poke commands, plus a command that rewinds the pointer to the table base.
- Setting the auxiliary converter timing and the received-signal-strength sample window.
- Handing the loaded table to an external processor, using a one-cycle request followed by an acknowledge.

Top module: `hostcmd_engine`

## Requirements
- R1: After reset, the output word (0xB2) and the status word (0xB6) read zero, done_irq is low, and rssi_start and rssi_len are zero. adc_n is 24 and adc_cycles is 529.
- R2: A write of a nonzero code to 0xB4 while idle starts a command. Status bit 1 (busy) then stays high until completion, and status bits [15:8] show the running code. A write of 0x00 to 0xB4 starts nothing.
- R3: On completion, done_irq and status bit 0 rise in the same cycle that busy falls, and status bits [15:8] read zero. A read of 0xB6 clears the done bit.
- R4: Code 0x10 resets the table pointer to 0 and loads 0 into the output word.
- R5: Code 0x04 performs one table write of word 0 (0xB0) at the pointer. It advances the pointer by one and loads the new pointer into the output word. done_irq rises two clock edges after the edge that captures the command write.
- R6: Code 0x08 writes word 0 at the pointer and word 1 (0xB1) at the next location, on consecutive cycles. It advances the pointer by two and loads the new pointer into the output word. done_irq rises three edges after the command edge.
- R7: The table pointer and the second poke address wrap from DEPTH-1 to 0.
- R8: Code 0x0D loads word 0 into adc_n, clamped into 24..256. adc_cycles becomes 22*adc_n+1.
- R9: Code 0x12 loads rssi_start from word 0 and rssi_len from word 1.
- R10: Code 0x0F raises tbl_proc for exactly one cycle. Completion comes only after proc_ack is seen.
- R11: Any other nonzero code completes two edges after the command edge. It makes no table write and leaves the output word and the configuration unchanged.
- R12: Writes to 0xB0, 0xB1 and 0xB4 while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the address |
| done_irq | output | 1 | Command-done interrupt flag |
| tbl_we | output | 1 | Table write enable |
| tbl_addr | output | PTR_W | Table write address |
| tbl_wdata | output | 16 | Table write data |
| tbl_proc | output | 1 | One-cycle request to process the table |
| proc_ack | input | 1 | Table processing finished |
| adc_n | output | 9 | Converter time setting |
| adc_cycles | output | 13 | Conversion period in reference clock cycles |
| rssi_start | output | 16 | First sample of the strength window |
| rssi_len | output | 16 | Number of samples in the window |

## Verification
The bench targets pointer wrap, including a two-word poke that starts at the last table location. A design that wraps wrongly would write the second word outside the table, or leave the pointer one step off.

It drives converter settings below, at and above both limits. A missing or inverted clamp would show an out-of-range adc_n or a wrong period.

It writes new operands and a second command while a table-processing request waits for its acknowledge. A design that latched those writes would poke the stray data or restart. A design that completed early would raise done before the acknowledge.

Unknown codes and a zero code check that neither touches the table or the output word, and that only a nonzero code sets busy.

// File: rtl/hostcmd_pkg.sv
package hostcmd_pkg;
  localparam logic [7:0] ADDR_IN0  = 8'hB0;
  localparam logic [7:0] ADDR_IN1  = 8'hB1;
  localparam logic [7:0] ADDR_OUT  = 8'hB2;
  localparam logic [7:0] ADDR_CMD  = 8'hB4;
  localparam logic [7:0] ADDR_STAT = 8'hB6;

  localparam logic [7:0] OP_POKE  = 8'h04;
  localparam logic [7:0] OP_POKE2 = 8'h08;
  localparam logic [7:0] OP_ADC   = 8'h0D;
  localparam logic [7:0] OP_PROC  = 8'h0F;
  localparam logic [7:0] OP_BASE  = 8'h10;
  localparam logic [7:0] OP_RSSI  = 8'h12;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EXEC,
    S_POKE_HI,
    S_WAIT_ACK,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/hostcmd_rstsync.sv
module hostcmd_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/hostcmd_regs.sv
module hostcmd_regs
  import hostcmd_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          busy,
  input  logic [CW-1:0] cmd_cur,
  input  logic          done_set,
  input  logic          out_load,
  input  logic [DW-1:0] out_val,
  output logic [DW-1:0] in0,
  output logic [DW-1:0] in1,
  output logic [DW-1:0] rdata,
  output logic          done_flag,
  output logic          start,
  output logic [CW-1:0] start_code
);
  logic [DW-1:0] in0_q, in0_d, in1_q, in1_d, out_q, out_d;
  logic          done_q, done_d;
  logic          wr_in0, wr_in1, stat_rd;
  logic [DW-1:0] stat_w;

  always_comb begin
    wr_in0     = bus_wr && (bus_addr == ADDR_IN0) && !busy;
    wr_in1     = bus_wr && (bus_addr == ADDR_IN1) && !busy;
    start_code = bus_wdata[CW-1:0];
    start      = bus_wr && (bus_addr == ADDR_CMD) && !busy && (start_code != '0);
    stat_rd    = bus_rd && (bus_addr == ADDR_STAT);

    in0_d  = wr_in0 ? bus_wdata : in0_q;
    in1_d  = wr_in1 ? bus_wdata : in1_q;
    out_d  = out_load ? out_val : out_q;
    if (done_set)     done_d = 1'b1;
    else if (stat_rd) done_d = 1'b0;
    else              done_d = done_q;

    stat_w            = '0;
    stat_w[0]         = done_q;
    stat_w[1]         = busy;
    stat_w[DW-1 -: CW] = cmd_cur;

    case (bus_addr)
      ADDR_OUT:  rdata = out_q;
      ADDR_STAT: rdata = stat_w;
      default:   rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in0_q  <= '0;
      in1_q  <= '0;
      out_q  <= '0;
      done_q <= 1'b0;
    end else begin
      in0_q  <= in0_d;
      in1_q  <= in1_d;
      out_q  <= out_d;
      done_q <= done_d;
    end
  end

  assign in0       = in0_q;
  assign in1       = in1_q;
  assign done_flag = done_q;
endmodule

// File: rtl/hostcmd_seq.sv
module hostcmd_seq
  import hostcmd_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 64,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    start_code,
  input  logic [DW-1:0]    in0,
  input  logic [DW-1:0]    in1,
  input  logic             proc_ack,
  output logic             busy,
  output logic [CW-1:0]    cmd_cur,
  output logic             tbl_we,
  output logic [PTR_W-1:0] tbl_addr,
  output logic [DW-1:0]    tbl_wdata,
  output logic             tbl_proc,
  output logic             adc_load,
  output logic             rssi_load,
  output logic             done_set,
  output logic             out_load,
  output logic [DW-1:0]    out_val
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  seq_state_e       state_q, state_d;
  logic [CW-1:0]    cmd_q, cmd_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_p1, ptr_p2;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    ptr_p1    = step(ptr_q);
    ptr_p2    = step(ptr_p1);
    state_d   = state_q;
    cmd_d     = cmd_q;
    ptr_d     = ptr_q;
    tbl_we    = 1'b0;
    tbl_addr  = ptr_q;
    tbl_wdata = in0;
    tbl_proc  = 1'b0;
    adc_load  = 1'b0;
    rssi_load = 1'b0;
    done_set  = 1'b0;
    out_load  = 1'b0;
    out_val   = DW'(ptr_p1);

    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_EXEC;
          cmd_d   = start_code;
        end
      end
      S_EXEC: begin
        state_d = S_DONE;
        case (cmd_q)
          OP_POKE: begin
            tbl_we   = 1'b1;
            ptr_d    = ptr_p1;
            out_load = 1'b1;
          end
          OP_POKE2: begin
            tbl_we  = 1'b1;
            state_d = S_POKE_HI;
          end
          OP_BASE: begin
            ptr_d    = '0;
            out_load = 1'b1;
            out_val  = '0;
          end
          OP_ADC:  adc_load  = 1'b1;
          OP_RSSI: rssi_load = 1'b1;
          OP_PROC: begin
            tbl_proc = 1'b1;
            state_d  = S_WAIT_ACK;
          end
          default: ;
        endcase
      end
      S_POKE_HI: begin
        tbl_we    = 1'b1;
        tbl_addr  = ptr_p1;
        tbl_wdata = in1;
        ptr_d     = ptr_p2;
        out_load  = 1'b1;
        out_val   = DW'(ptr_p2);
        state_d   = S_DONE;
      end
      S_WAIT_ACK: begin
        if (proc_ack) state_d = S_DONE;
      end
      S_DONE: begin
        done_set = 1'b1;
        cmd_d    = '0;
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cmd_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ptr_q   <= ptr_d;
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign cmd_cur = cmd_q;
endmodule

// File: rtl/hostcmd_cfg.sv
module hostcmd_cfg #(
  parameter int DW       = 16,
  parameter int ADC_MIN  = 24,
  parameter int ADC_MAX  = 256,
  parameter int ADC_MULT = 22,
  parameter int ADC_W    = 9,
  parameter int CYC_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_load,
  input  logic             rssi_load,
  input  logic [DW-1:0]    in0,
  input  logic [DW-1:0]    in1,
  output logic [ADC_W-1:0] adc_n,
  output logic [CYC_W-1:0] adc_cycles,
  output logic [DW-1:0]    rssi_start,
  output logic [DW-1:0]    rssi_len
);
  localparam logic [ADC_W-1:0] N_RST   = ADC_W'(ADC_MIN);
  localparam logic [CYC_W-1:0] CYC_RST = CYC_W'(ADC_MULT * ADC_MIN + 1);

  logic [ADC_W-1:0] n_q, n_d, n_clamp;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [DW-1:0]    rs_q, rs_d, rl_q, rl_d;

  always_comb begin
    if (in0 < DW'(ADC_MIN))      n_clamp = ADC_W'(ADC_MIN);
    else if (in0 > DW'(ADC_MAX)) n_clamp = ADC_W'(ADC_MAX);
    else                         n_clamp = in0[ADC_W-1:0];

    n_d   = adc_load ? n_clamp : n_q;
    cyc_d = adc_load ? (CYC_W'(ADC_MULT) * CYC_W'(n_clamp) + CYC_W'(1)) : cyc_q;
    rs_d  = rssi_load ? in0 : rs_q;
    rl_d  = rssi_load ? in1 : rl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= N_RST;
      cyc_q <= CYC_RST;
      rs_q  <= '0;
      rl_q  <= '0;
    end else begin
      n_q   <= n_d;
      cyc_q <= cyc_d;
      rs_q  <= rs_d;
      rl_q  <= rl_d;
    end
  end

  assign adc_n      = n_q;
  assign adc_cycles = cyc_q;
  assign rssi_start = rs_q;
  assign rssi_len   = rl_q;
endmodule

// File: rtl/hostcmd_engine.sv
module hostcmd_engine
  import hostcmd_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 8,
  parameter int DEPTH    = 64,
  parameter int ADC_MIN  = 24,
  parameter int ADC_MAX  = 256,
  parameter int ADC_MULT = 22,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int ADC_W   = $clog2(ADC_MAX + 1),
  localparam int CYC_W   = $clog2(ADC_MULT * ADC_MAX + 2)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             done_irq,
  output logic             tbl_we,
  output logic [PTR_W-1:0] tbl_addr,
  output logic [DW-1:0]    tbl_wdata,
  output logic             tbl_proc,
  input  logic             proc_ack,
  output logic [ADC_W-1:0] adc_n,
  output logic [CYC_W-1:0] adc_cycles,
  output logic [DW-1:0]    rssi_start,
  output logic [DW-1:0]    rssi_len
);
  logic          rst_n_s;
  logic          busy, start, done_set, out_load, adc_load, rssi_load;
  logic [CW-1:0] cmd_cur, start_code;
  logic [DW-1:0] in0_w, in1_w, out_val;

  hostcmd_rstsync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n_s)
  );

  hostcmd_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .cmd_cur    (cmd_cur),
    .done_set   (done_set),
    .out_load   (out_load),
    .out_val    (out_val),
    .in0        (in0_w),
    .in1        (in1_w),
    .rdata      (bus_rdata),
    .done_flag  (done_irq),
    .start      (start),
    .start_code (start_code)
  );

  hostcmd_seq #(.DW(DW), .CW(CW), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (start),
    .start_code (start_code),
    .in0        (in0_w),
    .in1        (in1_w),
    .proc_ack   (proc_ack),
    .busy       (busy),
    .cmd_cur    (cmd_cur),
    .tbl_we     (tbl_we),
    .tbl_addr   (tbl_addr),
    .tbl_wdata  (tbl_wdata),
    .tbl_proc   (tbl_proc),
    .adc_load   (adc_load),
    .rssi_load  (rssi_load),
    .done_set   (done_set),
    .out_load   (out_load),
    .out_val    (out_val)
  );

  hostcmd_cfg #(
    .DW(DW), .ADC_MIN(ADC_MIN), .ADC_MAX(ADC_MAX), .ADC_MULT(ADC_MULT),
    .ADC_W(ADC_W), .CYC_W(CYC_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .adc_load   (adc_load),
    .rssi_load  (rssi_load),
    .in0        (in0_w),
    .in1        (in1_w),
    .adc_n      (adc_n),
    .adc_cycles (adc_cycles),
    .rssi_start (rssi_start),
    .rssi_len   (rssi_len)
  );
endmodule

// File: rtl/hostcmd_engine_chk.sv
module hostcmd_engine_chk
  import hostcmd_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CW      = 8,
  parameter int ADC_MIN = 24,
  parameter int ADC_MAX = 256,
  parameter int ADC_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done_irq,
  input logic [CW-1:0]    cmd_cur,
  input logic             tbl_we,
  input logic             tbl_proc,
  input logic [ADC_W-1:0] adc_n,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    in0
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_wr && bus_addr == ADDR_CMD && bus_wdata[CW-1:0] != '0) |=> busy); // R2

  AST_DONE_CLEARS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> (cmd_cur == '0 && !busy)); // R3

  AST_TBL_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> busy); // R5

  AST_ADC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_n >= ADC_W'(ADC_MIN) && adc_n <= ADC_W'(ADC_MAX))); // R8

  AST_PROC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_proc |=> !tbl_proc); // R10

  AST_IN0_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == ADDR_IN0) |=> $stable(in0)); // R12
endmodule

bind hostcmd_engine hostcmd_engine_chk #(
  .DW(DW), .CW(CW), .ADC_MIN(ADC_MIN), .ADC_MAX(ADC_MAX), .ADC_W(ADC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .busy      (busy),
  .done_irq  (done_irq),
  .cmd_cur   (cmd_cur),
  .tbl_we    (tbl_we),
  .tbl_proc  (tbl_proc),
  .adc_n     (adc_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .in0       (in0_w)
);

// File: tb/hostcmd_engine_bench.sv
`timescale 1ns/1ps
module hostcmd_engine_bench;
  localparam int DEPTH = 16;
  localparam int PW    = 4;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        bus_wr, bus_rd, proc_ack;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        done_irq, tbl_we, tbl_proc;
  logic [PW-1:0] tbl_addr;
  logic [15:0] tbl_wdata, rssi_start, rssi_len;
  logic [8:0]  adc_n;
  logic [12:0] adc_cycles;

  always #2 clk = ~clk;

  hostcmd_engine #(.DEPTH(DEPTH)) u_hostcmd_engine (
    .clk(clk), .arst_n(arst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_irq(done_irq), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_proc(tbl_proc), .proc_ack(proc_ack),
    .adc_n(adc_n), .adc_cycles(adc_cycles),
    .rssi_start(rssi_start), .rssi_len(rssi_len)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cap_n, proc_n;
  logic [PW-1:0] cap_addr [0:7];
  logic [15:0]   cap_data [0:7];
  int m_ptr, m_out, m_in0, m_in1, m_adc, m_rs, m_rl;

  always @(posedge clk) begin
    if (tbl_we) begin
      if (cap_n < 8) begin
        cap_addr[cap_n] = tbl_addr;
        cap_data[cap_n] = tbl_wdata;
      end
      cap_n = cap_n + 1;
    end
    if (tbl_proc) proc_n = proc_n + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wrapi(input int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  function automatic int clampi(input int v);
    if (v < 24) return 24;
    if (v > 256) return 256;
    return v;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic issue(input logic [7:0] code);
    int lat, ack_cnt;
    bit seen_proc, ack_given;
    logic [15:0] s;
    lat = 0; ack_cnt = 0; seen_proc = 0; ack_given = 0;
    cap_n = 0; proc_n = 0;
    bus_write(8'hB4, {8'h00, code});
    while (!done_irq && lat < 60) begin
      if (seen_proc && !ack_given) begin
        if (ack_cnt == 0) begin proc_ack = 1'b1; ack_given = 1; end
        else ack_cnt--;
      end else if (tbl_proc && !seen_proc) begin
        seen_proc = 1; ack_cnt = $urandom % 4;
      end
      @(negedge clk);
      proc_ack = 1'b0;
      lat++;
    end
    chk("R3 done within limit", done_irq, 1);
    case (code)
      8'h04: begin
        chk("R5 poke latency", lat, 2);
        chk("R5 poke write count", cap_n, 1);
        chk("R5 poke addr", cap_addr[0], m_ptr);
        chk("R5 poke data", cap_data[0], m_in0);
        m_ptr = wrapi(m_ptr); m_out = m_ptr;
      end
      8'h08: begin
        chk("R6 poke2 latency", lat, 3);
        chk("R6 poke2 write count", cap_n, 2);
        chk("R6 poke2 addr lo", cap_addr[0], m_ptr);
        chk("R6 poke2 data lo", cap_data[0], m_in0);
        chk("R7 poke2 addr hi", cap_addr[1], wrapi(m_ptr));
        chk("R6 poke2 data hi", cap_data[1], m_in1);
        m_ptr = wrapi(wrapi(m_ptr)); m_out = m_ptr;
      end
      8'h10: begin
        chk("R4 base no write", cap_n, 0);
        m_ptr = 0; m_out = 0;
      end
      8'h0D: m_adc = clampi(m_in0);
      8'h12: begin m_rs = m_in0; m_rl = m_in1; end
      8'h0F: begin
        chk("R10 single proc pulse", proc_n, 1);
        chk("R10 done only after ack", int'(ack_given), 1);
      end
      default: begin
        chk("R11 unlisted latency", lat, 2);
        chk("R11 unlisted no write", cap_n, 0);
      end
    endcase
    chk("R8 adc_n", adc_n, m_adc);
    chk("R8 adc_cycles", adc_cycles, 22 * m_adc + 1);
    chk("R9 rssi_start", rssi_start, m_rs);
    chk("R9 rssi_len", rssi_len, m_rl);
    bus_read(8'hB6, s);
    chk("R3 status after done", s, 16'h0001);
    bus_read(8'hB6, s);
    chk("R3 read clears done", s, 16'h0000);
    bus_read(8'hB2, s);
    chk("R5 output word", s, m_out);
  endtask

  task automatic run_cmd(input logic [7:0] code, input logic [15:0] a, input logic [15:0] b);
    bus_write(8'hB0, a); m_in0 = a;
    bus_write(8'hB1, b); m_in1 = b;
    issue(code);
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] s;
    logic [7:0]  c;
    void'($urandom(32'h1F2E3D4C));
    arst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; proc_ack = 0;
    cap_n = 0; proc_n = 0;
    m_ptr = 0; m_out = 0; m_in0 = 0; m_in1 = 0; m_adc = 24; m_rs = 0; m_rl = 0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 done_irq", done_irq, 0);
    chk("R1 adc_n", adc_n, 24);
    chk("R1 adc_cycles", adc_cycles, 529);
    chk("R1 rssi_start", rssi_start, 0);
    chk("R1 rssi_len", rssi_len, 0);
    bus_read(8'hB6, s); chk("R1 status", s, 0);
    bus_read(8'hB2, s); chk("R1 out word", s, 0);

    // R2 zero code starts nothing
    bus_write(8'hB4, 16'h0000);
    bus_read(8'hB6, s); chk("R2 zero code not busy", s, 0);
    repeat (3) @(negedge clk);
    chk("R2 zero code no done", done_irq, 0);

    // R4, R5, R6, R7 fill and wrap
    run_cmd(8'h10, 16'h0, 16'h0);
    for (int i = 0; i < DEPTH - 1; i++) run_cmd(8'h04, 16'(16'hA000 + i), 16'h0);
    run_cmd(8'h08, 16'h5A5A, 16'hC3C3);
    run_cmd(8'h04, 16'h7777, 16'h0);

    // R8 clamp edges
    run_cmd(8'h0D, 16'd0, 16'h0);
    run_cmd(8'h0D, 16'd23, 16'h0);
    run_cmd(8'h0D, 16'd24, 16'h0);
    run_cmd(8'h0D, 16'd256, 16'h0);
    run_cmd(8'h0D, 16'd257, 16'h0);
    run_cmd(8'h0D, 16'hFFFF, 16'h0);
    run_cmd(8'h0D, 16'd100, 16'h0);

    // R9, R11
    run_cmd(8'h12, 16'd37, 16'd512);
    run_cmd(8'h05, 16'h1234, 16'h4321);
    run_cmd(8'hFF, 16'h1234, 16'h4321);

    // R12 writes ignored while busy, R10 wait for ack
    bus_write(8'hB0, 16'h1111); m_in0 = 16'h1111;
    bus_write(8'hB1, 16'h2222); m_in1 = 16'h2222;
    cap_n = 0; proc_n = 0;
    bus_write(8'hB4, 16'h000F);
    bus_write(8'hB0, 16'hDEAD);
    bus_write(8'hB1, 16'hBEEF);
    bus_write(8'hB4, 16'h0004);
    bus_read(8'hB6, s);
    chk("R2 busy and code shown", s & 16'hFF02, 16'h0F02);
    chk("R10 no done before ack", done_irq, 0);
    @(negedge clk); proc_ack = 1'b1;
    @(negedge clk); proc_ack = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 done after ack", done_irq, 1);
    chk("R12 no table write while busy", cap_n, 0);
    chk("R10 proc pulse count", proc_n, 1);
    bus_read(8'hB6, s);
    chk("R3 status clean", s, 16'h0001);
    issue(8'h04);
    issue(8'h08);

    // random mix
    for (int k = 0; k < 300; k++) begin
      int r;
      logic [15:0] a, b;
      r = $urandom % 8;
      a = (($urandom % 2) == 0) ? 16'($urandom % 320) : 16'($urandom);
      b = 16'($urandom);
      case (r)
        0, 7: c = 8'h04;
        1: c = 8'h08;
        2: c = (($urandom % 4) == 0) ? 8'h10 : 8'h04;
        3: c = 8'h0D;
        4: c = 8'h12;
        5: c = 8'h0F;
        default: begin
          c = 8'($urandom);
          if (c == 8'h00 || c == 8'h04 || c == 8'h08 || c == 8'h0D ||
              c == 8'h0F || c == 8'h10 || c == 8'h12) c = 8'h01;
        end
      endcase
      run_cmd(c, a, b);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule